// File: doc/BRIEF.md
# Streaming 3x3 Pixel Neighbourhood Builder

This block takes a raster-ordered stream of 8-bit pixels, one per cycle on which the input strobe is high, and turns it into a 3x3 neighbourhood of pixels for a downstream spatial filter. The image line width is a compile-time parameter. Internally a single delay chain of `2*LINE_W+3` pixel registers is kept. The chain advances by one place only when a pixel is accepted, and nine fixed taps on it form the window.

A fill counter tracks how many pixels have arrived since reset and saturates once the chain is full. From that point a fresh window is available after every accepted pixel. Windows whose columns wrap across a line boundary are still flagged valid. Masking those windows is the job of the consumer.

Top module: `nbhd_window3x3`

## Requirements
- R1: While `rst` is high (asynchronous, active high), every tap output and `winValid` read zero, without waiting for a clock edge.
- R2: On a rising edge where `pixValid` is high, the pixel on `pixIn` appears on `tapR0C0` after that edge.
- R3: On a rising edge where `pixValid` is low, all nine taps and `winValid` keep their values.
- R4: `tapRkCj` (row k and column j, each 0..2) shows the pixel accepted `k*LINE_W+j` acceptances before the most recent one. It reads zero when fewer than `k*LINE_W+j+1` pixels have been accepted since reset. Row 0 and column 0 therefore hold the newest pixel.
- R5: `winValid` is low until `2*LINE_W+3` pixels have been accepted since reset, and goes high right after the edge that accepts pixel number `2*LINE_W+3`.
- R6: Once high, `winValid` stays high through further pixels and idle cycles until reset, and this includes windows that straddle a line wrap.
- R7: A reset in mid-stream restarts the fill, so `winValid` needs another `2*LINE_W+3` accepted pixels before it rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Asynchronous active-high reset |
| pixValid | input | 1 | Pixel strobe; the chain advances only when high |
| pixIn | input | PIX_W | Incoming pixel, raster order |
| tapR0C0 | output | PIX_W | Newest row, newest column |
| tapR0C1 | output | PIX_W | Row 0, column 1 |
| tapR0C2 | output | PIX_W | Row 0, column 2 |
| tapR1C0 | output | PIX_W | Row 1 (one line older), column 0 |
| tapR1C1 | output | PIX_W | Row 1, column 1 (window centre) |
| tapR1C2 | output | PIX_W | Row 1, column 2 |
| tapR2C0 | output | PIX_W | Row 2 (two lines older), column 0 |
| tapR2C1 | output | PIX_W | Row 2, column 1 |
| tapR2C2 | output | PIX_W | Row 2, column 2 (oldest pixel) |
| winValid | output | 1 | High once the chain has been filled since reset |

## Verification
The taps and `winValid` have exactly one register stage between input and output. Each result is therefore due after the rising edge that accepts a pixel, and the bench drives and samples on the falling edge. After each edge it compares all nine taps and `winValid` against a history of the accepted pixels. Reset acts without a clock, so the bench checks it a fraction of a cycle after `rst` rises, before any edge has occurred. The bench runs a directed fill that stops one pixel short of the threshold and then crosses it, an idle stretch, a long randomly gapped stream, and a reset in mid-stream.

// File: rtl/nbhd_pkg.sv
package nbhd_pkg;

  // Strobes from fill control to the pixel chain
  typedef struct packed {
    logic shiftEn;   // advance the chain this cycle
    logic winFull;   // chain holds a complete neighbourhood
  } nbhdStrb_t;

  localparam int unsigned NBHD_ROWS = 3;
  localparam int unsigned NBHD_COLS = 3;
  localparam int unsigned NBHD_TAPS = NBHD_ROWS * NBHD_COLS;

endpackage

// File: rtl/nbhd_fill_ctrl.sv
module nbhd_fill_ctrl
  import nbhd_pkg::*;
#(
  parameter int unsigned DEPTH = 1283
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      pixValid,
  output nbhdStrb_t strb
);

  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [CW-1:0] fillCnt;
  logic          atFull;

  assign atFull = (fillCnt == FULL_CNT);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      fillCnt <= '0;
    end else if (pixValid && !atFull) begin
      fillCnt <= fillCnt + CW'(1);
    end
  end

  always_comb begin
    strb.shiftEn = pixValid;
    strb.winFull = atFull;
  end

  // R5
  fill_step_chk: assert property (@(posedge clk) disable iff (rst)
    (pixValid && !atFull) |=> (fillCnt == $past(fillCnt) + CW'(1)));

  // R6
  full_hold_chk: assert property (@(posedge clk) disable iff (rst)
    strb.winFull |=> strb.winFull);

  // R3
  idle_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    !pixValid |=> $stable(fillCnt));

endmodule

// File: rtl/nbhd_shift_chain.sv
module nbhd_shift_chain
  import nbhd_pkg::*;
#(
  parameter int unsigned LINE_W = 640,
  parameter int unsigned PIX_W  = 8
) (
  input  logic                               clk,
  input  logic                               rst,
  input  nbhdStrb_t                          strb,
  input  logic [PIX_W-1:0]                   pixIn,
  output logic [NBHD_TAPS-1:0][PIX_W-1:0]    taps
);

  localparam int unsigned DEPTH = 2 * LINE_W + 3;

  logic [PIX_W-1:0] chain [DEPTH];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) chain[i] <= '0;
    end else if (strb.shiftEn) begin
      chain[0] <= pixIn;
      for (int i = 1; i < DEPTH; i++) chain[i] <= chain[i-1];
    end
  end

  for (genvar k = 0; k < NBHD_ROWS; k++) begin : g_row
    for (genvar j = 0; j < NBHD_COLS; j++) begin : g_col
      assign taps[k*NBHD_COLS + j] = chain[k*LINE_W + j];
    end
  end

  // R2
  head_load_chk: assert property (@(posedge clk) disable iff (rst)
    strb.shiftEn |=> (chain[0] == $past(pixIn)));

  // R4
  tail_step_chk: assert property (@(posedge clk) disable iff (rst)
    strb.shiftEn |=> (chain[DEPTH-1] == $past(chain[DEPTH-2])));

  // R3
  chain_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.shiftEn |=> ($stable(chain[0]) && $stable(chain[DEPTH-1])));

endmodule

// File: rtl/nbhd_window3x3.sv
module nbhd_window3x3
  import nbhd_pkg::*;
#(
  parameter int unsigned LINE_W = 640,
  parameter int unsigned PIX_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pixValid,
  input  logic [PIX_W-1:0] pixIn,
  output logic [PIX_W-1:0] tapR0C0,
  output logic [PIX_W-1:0] tapR0C1,
  output logic [PIX_W-1:0] tapR0C2,
  output logic [PIX_W-1:0] tapR1C0,
  output logic [PIX_W-1:0] tapR1C1,
  output logic [PIX_W-1:0] tapR1C2,
  output logic [PIX_W-1:0] tapR2C0,
  output logic [PIX_W-1:0] tapR2C1,
  output logic [PIX_W-1:0] tapR2C2,
  output logic             winValid
);

  localparam int unsigned DEPTH = 2 * LINE_W + 3;

  nbhdStrb_t                            strb;
  logic [NBHD_TAPS-1:0][PIX_W-1:0]      taps;

  nbhd_fill_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .pixValid (pixValid),
    .strb     (strb)
  );

  nbhd_shift_chain #(.LINE_W(LINE_W), .PIX_W(PIX_W)) u_chain (
    .clk   (clk),
    .rst   (rst),
    .strb  (strb),
    .pixIn (pixIn),
    .taps  (taps)
  );

  assign tapR0C0  = taps[0];
  assign tapR0C1  = taps[1];
  assign tapR0C2  = taps[2];
  assign tapR1C0  = taps[3];
  assign tapR1C1  = taps[4];
  assign tapR1C2  = taps[5];
  assign tapR2C0  = taps[6];
  assign tapR2C1  = taps[7];
  assign tapR2C2  = taps[8];
  assign winValid = strb.winFull;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |-> (!winValid && tapR0C0 == '0 && tapR2C2 == '0));

endmodule

// File: tb/sim_nbhd_window3x3.sv
module sim_nbhd_window3x3;

  localparam int unsigned W     = 12;
  localparam int unsigned DEPTH = 2 * W + 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pixValid = 1'b0;
  logic [7:0] pixIn = '0;
  logic [7:0] dutTap [9];
  logic       winValid;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [7:0] hist [0:4095];
  int accN = 0;

  always #5 clk = ~clk;

  nbhd_window3x3 #(.LINE_W(W), .PIX_W(8)) u0 (
    .clk(clk), .rst(rst), .pixValid(pixValid), .pixIn(pixIn),
    .tapR0C0(dutTap[0]), .tapR0C1(dutTap[1]), .tapR0C2(dutTap[2]),
    .tapR1C0(dutTap[3]), .tapR1C1(dutTap[4]), .tapR1C2(dutTap[5]),
    .tapR2C0(dutTap[6]), .tapR2C1(dutTap[7]), .tapR2C2(dutTap[8]),
    .winValid(winValid)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: run hung, got %0d cycles expected < 100000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [7:0] expTap(int k, int j);
    int off = k * W + j;
    if (accN > off) return hist[accN - 1 - off];
    return 8'h00;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Compare every output against the accepted-pixel history
  task automatic checkAll(string wvTag);
    for (int k = 0; k < 3; k++) begin
      for (int j = 0; j < 3; j++) begin
        chk((k == 0 && j == 0) ? "R2" : "R4", $sformatf("tap r%0d c%0d", k, j),
            dutTap[k*3+j], expTap(k, j));
      end
    end
    chk(wvTag, "winValid", winValid, (accN >= DEPTH) ? 1 : 0);
  endtask

  task automatic step(bit v, logic [7:0] d, string wvTag);
    pixValid = v;
    pixIn    = d;
    @(posedge clk);
    if (v) begin
      hist[accN] = d;
      accN++;
    end
    @(negedge clk);
    checkAll(wvTag);
  endtask

  initial begin
    void'($urandom(32'd4242));
    // R1: reset state
    repeat (3) @(negedge clk);
    for (int i = 0; i < 9; i++) chk("R1", "tap in reset", dutTap[i], 0);
    chk("R1", "winValid in reset", winValid, 0);
    rst = 1'b0;
    @(negedge clk);

    // R5: directed fill up to one short of the threshold
    for (int i = 0; i < DEPTH - 1; i++) step(1'b1, 8'(i + 1), "R5");
    chk("R5", "winValid one short", winValid, 0);
    step(1'b1, 8'hA5, "R5");
    chk("R5", "winValid at threshold", winValid, 1);

    // R3: idle stretch with changing data that must not enter
    for (int i = 0; i < 10; i++) step(1'b0, 8'($urandom), "R3");

    // R6: long gapped random stream, crossing many line wraps
    for (int i = 0; i < 600; i++) step(($urandom % 4) != 0, 8'($urandom), "R6");

    // R7: asynchronous reset in mid-stream
    rst = 1'b1;
    #1;
    for (int i = 0; i < 9; i++) chk("R1", "tap after async reset", dutTap[i], 0);
    chk("R7", "winValid after async reset", winValid, 0);
    accN = 0;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 300; i++) step(($urandom % 3) != 0, 8'($urandom), "R7");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule